// File: doc/BRIEF.md
# Gated Frequency Counter Controller

This block measures the frequency of an input signal. It counts the rising edges of that signal while a gate window is open, and it keeps the result as four decimal digits. A three-state sequencer follows a START level. While idle it holds the count cleared. When START rises it opens the gate. When START falls it closes the gate and freezes the count, so the count can be shown until the next measurement.

The measured input is brought into the system clock domain through a two-flop synchronizer. An edge detector then gives one count per rising edge. For this reason the input must toggle slower than half the system clock. The four digits form a decade chain: a digit steps only when every lower digit is at nine. Seven-segment decoding and the timing of the START window are done outside the block.

Top module: `freq_gate_counter`

## Requirements
- R1: While `rst` is 1 at a clock edge, the block goes to the idle state. After that edge `gate` is 0, `cnt_clr` is 1 and all four digits are 0.
- R2: In the idle state, `start` at 1 moves the block to the counting state at the next edge. There `gate` is 1 and `cnt_clr` is 0.
- R3: In the counting state, `start` at 0 moves the block to the hold state at the next edge. There `gate` is 0 and `cnt_clr` is 0.
- R4: After a counting window, the digits equal the number of rising edges of `sig_in` seen while `gate` was 1, modulo 10000. Each digit is 4-bit BCD. `dig0` is the units digit and `dig3` is the thousands digit.
- R5: While `start` stays 0, the hold state persists. In that state the digits do not change, and edges on `sig_in` are ignored.
- R6: In the hold state, `start` at 1 sends the block to idle for exactly one cycle (`cnt_clr` 1, `gate` 0). The block then enters the counting state with all digits at 0.
- R7: Each digit holds only the values 0 to 9. From 9 it wraps to 0 and carries into the next digit. One edge at a count of 9999 gives 0000.
- R8: In the idle state the digits stay 0 whatever `sig_in` does. The clear takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Measurement window level |
| sig_in | input | 1 | Measured input, asynchronous |
| gate | output | 1 | High while edges are counted |
| cnt_clr | output | 1 | High while the count is held cleared |
| dig0 | output | 4 | BCD units digit |
| dig1 | output | 4 | BCD tens digit |
| dig2 | output | 4 | BCD hundreds digit |
| dig3 | output | 4 | BCD thousands digit |

## Verification
The hardest case to reach is the wrap of the full chain from 9999 to 0000, because it takes ten thousand counted edges inside one window. The stimulus keeps `start` high and pulses `sig_in` at three clock cycles per edge. It does this once for exactly 9999 edges and once for 10003 edges. A second hard case is the one-cycle idle pass on the way from hold back to counting. The bench samples at the falling edge right after `start` rises in the hold state, so it sees the lone cycle with the clear high. Random windows with random pulse widths fill in the ordinary counts.

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
  parameter int DIGITS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       sig_in,
  output logic       gate,
  output logic       cnt_clr,
  output logic [3:0] dig0,
  output logic [3:0] dig1,
  output logic [3:0] dig2,
  output logic [3:0] dig3
);

  typedef enum logic [1:0] {S_IDLE, S_OPEN, S_HOLD} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else begin
      case (state)
        S_IDLE:  if (start)  state <= S_OPEN;
        S_OPEN:  if (!start) state <= S_HOLD;
        S_HOLD:  if (start)  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign gate    = (state == S_OPEN);
  assign cnt_clr = (state == S_IDLE);

  logic [2:0] sync;
  always_ff @(posedge clk) begin
    if (rst) sync <= '0;
    else     sync <= {sync[1:0], sig_in};
  end
  wire rise = sync[1] & ~sync[2];

  logic [3:0] dig [DIGITS];
  logic [DIGITS:0] en;
  assign en[0] = gate & rise;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign en[i+1] = en[i] && (dig[i] == 4'd9);
    always_ff @(posedge clk) begin
      if (rst || cnt_clr)  dig[i] <= 4'd0;
      else if (en[i])      dig[i] <= (dig[i] == 4'd9) ? 4'd0 : dig[i] + 4'd1;
    end
    a_r7_bcd_range: assert property (@(posedge clk) disable iff (rst) dig[i] <= 4'd9);
  end

  assign dig0 = dig[0];
  assign dig1 = dig[1];
  assign dig2 = dig[2];
  assign dig3 = dig[3];

  a_r2_open: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr && start) |=> (gate && !cnt_clr));
  a_r3_close: assert property (@(posedge clk) disable iff (rst)
    (gate && !start) |=> (!gate && !cnt_clr));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!gate && !cnt_clr && !start) |=> ($stable({dig0, dig1, dig2, dig3}) && !gate && !cnt_clr));
  a_r6_idle_pass: assert property (@(posedge clk) disable iff (rst)
    (!gate && !cnt_clr && start) |=> (cnt_clr && !gate));
  a_r8_cleared: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> ({dig0, dig1, dig2, dig3} == 16'h0));
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (gate && !rise) |=> $stable({dig0, dig1, dig2, dig3}));

endmodule

// File: tb/test_freq_gate_counter.sv
module test_freq_gate_counter;
  logic clk = 0, rst = 1, start = 0, sig_in = 0;
  logic gate, cnt_clr;
  logic [3:0] dig0, dig1, dig2, dig3;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  freq_gate_counter i_freq_gate_counter (
    .clk(clk), .rst(rst), .start(start), .sig_in(sig_in),
    .gate(gate), .cnt_clr(cnt_clr),
    .dig0(dig0), .dig1(dig1), .dig2(dig2), .dig3(dig3));

  function automatic logic [15:0] to_bcd(int n);
    int m = n % 10000;
    return {4'(m / 1000), 4'((m / 100) % 10), 4'((m / 10) % 10), 4'(m % 10)};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int k = 0; k < n; k++) begin
      sig_in = 1; cyc(hi);
      sig_in = 0; cyc(lo);
    end
  endtask

  function automatic logic [15:0] cnt();
    return {dig3, dig2, dig1, dig0};
  endfunction

  task automatic window(int n, int hi, int lo);
    start = 1; cyc(4);
    pulses(n, hi, lo);
    cyc(4);
    start = 0; cyc(2);
  endtask

  task automatic restart;
    start = 1; cyc(1);
    start = 0; cyc(1);
  endtask

  initial begin
    cyc(50000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    check("R1 reset flags", {14'd0, gate, cnt_clr}, 16'h1);
    check("R1 reset digits", cnt(), 16'h0);
    rst = 0; cyc(1);

    pulses(5, 1, 2);
    check("R8 idle ignores input", cnt(), 16'h0);

    start = 1; cyc(1);
    check("R2 open flags", {14'd0, gate, cnt_clr}, 16'h2);
    cyc(3);
    pulses(37, 1, 2);
    cyc(4);
    start = 0; cyc(1);
    check("R3 hold flags", {14'd0, gate, cnt_clr}, 16'h0);
    cyc(1);
    check("R4 count 37", cnt(), to_bcd(37));

    pulses(20, 2, 2);
    cyc(50);
    check("R5 hold count", cnt(), to_bcd(37));
    check("R5 hold flags", {14'd0, gate, cnt_clr}, 16'h0);

    start = 1; cyc(1);
    check("R6 idle pass flags", {14'd0, gate, cnt_clr}, 16'h1);
    cyc(1);
    check("R6 reopen flags", {14'd0, gate, cnt_clr}, 16'h2);
    check("R6 count cleared", cnt(), 16'h0);
    cyc(2);
    pulses(9999, 1, 2);
    cyc(4);
    start = 0; cyc(2);
    check("R7 count 9999", cnt(), 16'h9999);

    restart();
    window(10003, 1, 2);
    check("R7 wrap to 0003", cnt(), 16'h0003);

    for (int r = 0; r < 6; r++) begin
      int n = $urandom_range(250, 1);
      int hi = $urandom_range(3, 1);
      int lo = $urandom_range(4, 2);
      restart();
      window(n, hi, lo);
      check("R4 random window", cnt(), to_bcd(n));
    end

    start = 1; cyc(4);
    pulses(12, 1, 2);
    rst = 1; cyc(1);
    rst = 0;
    check("R1 reset mid count flags", {14'd0, gate, cnt_clr}, 16'h1);
    check("R1 reset mid count digits", cnt(), 16'h0);
    start = 0; cyc(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule